// File: doc/BRIEF.md
# SDRAM Command Decoder with Mode Registers

This block sits on the memory side of a single-data-rate SDRAM interface. It samples the control strobes, the clock-enable, the bank select and the address bus on every rising clock edge. It then turns the sampled pattern into a one-hot command strobe. It keeps the last two clock-enable samples, so it can recognise refresh-to-self-refresh, stop-to-deep-power-down and wake-up transitions.

The block also holds two configuration registers: a main mode register and an extended one. It presents their decoded fields to downstream logic. Those fields are burst length in beats, interleaved ordering, read latency, single-location writes, self-refresh bank coverage and output drive strength. Reserved settings are refused and reported through a sticky flag. A short guard window after every register load rejects row opens and refreshes.

Every output is registered. A command captured at edge n appears on the outputs after edge n+1.

Top module: `sdram_cmd_decode`

## Requirements
- R1: A command sampled at edge n shows on `cmd_o` after edge n+1, with at most one bit set. The bit positions are: 0 no-op, 1 deselect, 2 open row, 3 read, 4 write, 5 precharge, 6 auto refresh, 7 self-refresh entry, 8 main load, 9 extended load, 10 burst stop, 11 deep power-down entry. With `cs_n` high the command is deselect. With `cs_n` low, the levels {ras_n,cas_n,we_n} decode as follows: 011 open row, 101 read, 100 write, 010 precharge, 001 refresh, 000 register load, 111 no-op, 110 burst stop.
- R2: `cmd_bank_o` and `cmd_addr_o` carry the bank and address sampled with the command. `cmd_a10_o` carries address bit 10, which means auto-precharge on read and write and all banks on precharge.
- R3: Refresh with clock-enable high on both the previous and the current edge gives auto refresh (bit 6). With clock-enable high then low, it gives self-refresh entry (bit 7).
- R4: The burst-stop pattern gives bit 10 while clock-enable stays high. It gives deep power-down entry (bit 11) when clock-enable falls on that edge.
- R5: A register load with bank bits 00 targets the main register, and one with bank bits 10 targets the extended register. Any other bank value raises `illegal_o`, gives no strobe and leaves both registers unchanged.
- R6: The main register fields decode as follows. Bits 2:0 give the burst length: 000, 001, 010 and 011 give 1, 2, 4 and 8 beats, and 111 gives PAGE_COLS beats. Bit 3 set means interleaved ordering. Bits 6:4 give the read latency, where 010 means 2 and 011 means 3. Bit 9 set means single-location writes.
- R7: The extended register fields decode as follows. Bits 2:0 give the self-refresh bank mask: 000 all banks, 001 banks 0 and 1, 010 bank 0. Bits 6:5 give the drive strength code.
- R8: For the two commands after any register load, an open row or a refresh gives no strobe and raises `illegal_o`. The third command after the load is accepted.
- R9: While clock-enable was low on the previous edge and is still low, no strobe, `illegal_o` or `wake_o` is produced.
- R10: A low-to-high clock-enable transition raises `wake_o`. On that edge only no-op or deselect is accepted; any other command gives no strobe and raises `illegal_o`.
- R11: A load holding a reserved encoding sets `mode_bad_o` and leaves the decoded fields and valid bits unchanged. The reserved encodings are a read latency other than 2 or 3, a burst length code of 100 to 110, a full page with interleaved ordering, or a coverage code above 010. A later valid load of either register clears the flag.
- R12: After reset all command, flag and field outputs are zero, including both valid bits. Clock-enable history starts high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | BAW | Bank select |
| addr | input | AW | Address bus |
| cmd_o | output | 12 | One-hot command strobe |
| cmd_bank_o | output | BAW | Bank sampled with the command |
| cmd_addr_o | output | AW | Address sampled with the command |
| cmd_a10_o | output | 1 | Auto-precharge / all-bank bit |
| illegal_o | output | 1 | Command refused |
| wake_o | output | 1 | Clock-enable rose on this command |
| burst_beats_o | output | clog2(PAGE_COLS)+1 | Burst length in beats |
| burst_ilv_o | output | 1 | Interleaved burst ordering |
| cas_lat_o | output | 2 | Read latency in cycles |
| wr_single_o | output | 1 | Writes are single-location |
| mode_valid_o | output | 1 | Main register loaded with a valid value |
| mode_bad_o | output | 1 | Sticky reserved-setting flag |
| sr_banks_o | output | 2**BAW | Self-refresh bank mask |
| drv_str_o | output | 2 | Drive strength code |
| ext_valid_o | output | 1 | Extended register loaded with a valid value |

## Verification
A wrong clock-enable history shows up on the very next captured command. The outputs then swap auto refresh for self-refresh entry, or burst stop for deep power-down, or they raise a wake strobe that should not appear. A guard counter that is off by one shows up as an open row that is wrongly refused or wrongly accepted, exactly two or three commands after a load. Corrupted register contents show up one cycle after the load in the field outputs. The exhaustive sweeps of every field code reach those outputs within a couple of hundred cycles.

// File: rtl/sdram_dec_pkg.sv
package sdram_dec_pkg;
  localparam int NCMD     = 12;
  localparam int CI_NOP   = 0;
  localparam int CI_DESEL = 1;
  localparam int CI_ACT   = 2;
  localparam int CI_READ  = 3;
  localparam int CI_WRITE = 4;
  localparam int CI_PRE   = 5;
  localparam int CI_AREF  = 6;
  localparam int CI_SREF  = 7;
  localparam int CI_MRS   = 8;
  localparam int CI_EMRS  = 9;
  localparam int CI_BST   = 10;
  localparam int CI_DPD   = 11;

  typedef logic [NCMD-1:0] cmd_vec_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } ctl_t;
endpackage

// File: rtl/sdram_pin_capture.sv
module sdram_pin_capture
  import sdram_dec_pkg::*;
#(
  parameter int AW  = 13,
  parameter int BAW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  ctl_t           ctl_i,
  input  logic           cke_i,
  input  logic [BAW-1:0] ba_i,
  input  logic [AW-1:0]  addr_i,
  output ctl_t           ctl_q,
  output logic           cke_q,
  output logic           cke_prev_q,
  output logic [BAW-1:0] ba_q,
  output logic [AW-1:0]  addr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q      <= '1;
      cke_q      <= 1'b1;
      cke_prev_q <= 1'b1;
      ba_q       <= '0;
      addr_q     <= '0;
    end else begin
      ctl_q      <= ctl_i;
      cke_prev_q <= cke_q;
      cke_q      <= cke_i;
      ba_q       <= ba_i;
      addr_q     <= addr_i;
    end
  end
endmodule

// File: rtl/sdram_cmd_classify.sv
module sdram_cmd_classify
  import sdram_dec_pkg::*;
#(
  parameter int BAW = 2
) (
  input  ctl_t           ctl,
  input  logic           cke_now,
  input  logic           cke_prev,
  input  logic [BAW-1:0] ba,
  input  logic           blocked,
  output cmd_vec_t       cmd,
  output logic           illegal,
  output logic           wake
);
  localparam logic [BAW-1:0] SEL_MAIN = '0;
  localparam logic [BAW-1:0] SEL_EXT  = BAW'(1) << (BAW-1);

  cmd_vec_t raw;
  logic     bad_sel;
  logic     quiet;

  always_comb begin
    raw     = '0;
    bad_sel = 1'b0;
    if (ctl.cs_n) begin
      raw[CI_DESEL] = 1'b1;
    end else begin
      case ({ctl.ras_n, ctl.cas_n, ctl.we_n})
        3'b111: raw[CI_NOP]   = 1'b1;
        3'b011: raw[CI_ACT]   = 1'b1;
        3'b101: raw[CI_READ]  = 1'b1;
        3'b100: raw[CI_WRITE] = 1'b1;
        3'b010: raw[CI_PRE]   = 1'b1;
        3'b001: begin
          if (cke_now) raw[CI_AREF] = 1'b1;
          else         raw[CI_SREF] = 1'b1;
        end
        3'b110: begin
          if (cke_now) raw[CI_BST] = 1'b1;
          else         raw[CI_DPD] = 1'b1;
        end
        default: begin
          if (ba == SEL_MAIN)     raw[CI_MRS]  = 1'b1;
          else if (ba == SEL_EXT) raw[CI_EMRS] = 1'b1;
          else                    bad_sel      = 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    wake    = !cke_prev && cke_now;
    quiet   = raw[CI_NOP] || raw[CI_DESEL];
    cmd     = '0;
    illegal = 1'b0;
    if (!cke_prev) begin
      if (wake) begin
        if (quiet) cmd     = raw;
        else       illegal = 1'b1;
      end
    end else if (blocked && (raw[CI_ACT] || raw[CI_AREF] || raw[CI_SREF])) begin
      illegal = 1'b1;
    end else begin
      cmd     = raw;
      illegal = bad_sel;
    end
  end
endmodule

// File: rtl/sdram_mode_regs.sv
module sdram_mode_regs #(
  parameter int BAW       = 2,
  parameter int PAGE_COLS = 1024,
  localparam int NBANK    = 1 << BAW,
  localparam int CNTW     = $clog2(PAGE_COLS) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_mr,
  input  logic             ld_emr,
  input  logic [2:0]       bl_code,
  input  logic             bt,
  input  logic [2:0]       cl_code,
  input  logic             wr_one,
  input  logic [2:0]       pasr,
  input  logic [1:0]       drv,
  output logic [CNTW-1:0]  burst_beats,
  output logic             burst_ilv,
  output logic [1:0]       cas_lat,
  output logic             wr_single,
  output logic             mode_valid,
  output logic             mode_bad,
  output logic [NBANK-1:0] sr_banks,
  output logic [1:0]       drv_str,
  output logic             ext_valid
);
  logic             mr_ok;
  logic             emr_ok;
  logic [CNTW-1:0]  beats_n;
  logic [NBANK-1:0] mask_n;

  always_comb begin
    mr_ok   = (cl_code == 3'd2 || cl_code == 3'd3) &&
              (bl_code <= 3'd3 || (bl_code == 3'd7 && !bt));
    beats_n = (bl_code == 3'd7) ? CNTW'(PAGE_COLS) : (CNTW'(1) << bl_code[1:0]);
    emr_ok  = (pasr <= 3'd2);
    case (pasr)
      3'd0:    mask_n = '1;
      3'd1:    mask_n = NBANK'((1 << (NBANK / 2)) - 1);
      default: mask_n = NBANK'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_beats <= '0;
      burst_ilv   <= 1'b0;
      cas_lat     <= '0;
      wr_single   <= 1'b0;
      mode_valid  <= 1'b0;
      mode_bad    <= 1'b0;
      sr_banks    <= '0;
      drv_str     <= '0;
      ext_valid   <= 1'b0;
    end else if (ld_mr) begin
      if (mr_ok) begin
        burst_beats <= beats_n;
        burst_ilv   <= bt;
        cas_lat     <= cl_code[1:0];
        wr_single   <= wr_one;
        mode_valid  <= 1'b1;
        mode_bad    <= 1'b0;
      end else begin
        mode_bad    <= 1'b1;
      end
    end else if (ld_emr) begin
      if (emr_ok) begin
        sr_banks  <= mask_n;
        drv_str   <= drv;
        ext_valid <= 1'b1;
        mode_bad  <= 1'b0;
      end else begin
        mode_bad  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_dec_pkg::*;
#(
  parameter int AW        = 13,
  parameter int BAW       = 2,
  parameter int PAGE_COLS = 1024,
  parameter int MRD_CYC   = 2,
  localparam int NBANK    = 1 << BAW,
  localparam int CNTW     = $clog2(PAGE_COLS) + 1,
  localparam int GW       = $clog2(MRD_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             cke,
  input  logic [BAW-1:0]   ba,
  input  logic [AW-1:0]    addr,
  output logic [NCMD-1:0]  cmd_o,
  output logic [BAW-1:0]   cmd_bank_o,
  output logic [AW-1:0]    cmd_addr_o,
  output logic             cmd_a10_o,
  output logic             illegal_o,
  output logic             wake_o,
  output logic [CNTW-1:0]  burst_beats_o,
  output logic             burst_ilv_o,
  output logic [1:0]       cas_lat_o,
  output logic             wr_single_o,
  output logic             mode_valid_o,
  output logic             mode_bad_o,
  output logic [NBANK-1:0] sr_banks_o,
  output logic [1:0]       drv_str_o,
  output logic             ext_valid_o
);
  ctl_t           ctl_q;
  logic           cke_q, cke_prev_q;
  logic [BAW-1:0] ba_q;
  logic [AW-1:0]  addr_q;
  cmd_vec_t       cmd_c;
  logic           illegal_c, wake_c;
  logic [GW-1:0]  guard;

  sdram_pin_capture #(.AW(AW), .BAW(BAW)) u_cap (
    .clk(clk), .rst(rst),
    .ctl_i('{cs_n: cs_n, ras_n: ras_n, cas_n: cas_n, we_n: we_n}),
    .cke_i(cke), .ba_i(ba), .addr_i(addr),
    .ctl_q(ctl_q), .cke_q(cke_q), .cke_prev_q(cke_prev_q),
    .ba_q(ba_q), .addr_q(addr_q)
  );

  sdram_cmd_classify #(.BAW(BAW)) u_cls (
    .ctl(ctl_q), .cke_now(cke_q), .cke_prev(cke_prev_q), .ba(ba_q),
    .blocked(guard != '0), .cmd(cmd_c), .illegal(illegal_c), .wake(wake_c)
  );

  sdram_mode_regs #(.BAW(BAW), .PAGE_COLS(PAGE_COLS)) u_mr (
    .clk(clk), .rst(rst),
    .ld_mr(cmd_c[CI_MRS]), .ld_emr(cmd_c[CI_EMRS]),
    .bl_code(addr_q[2:0]), .bt(addr_q[3]), .cl_code(addr_q[6:4]),
    .wr_one(addr_q[9]), .pasr(addr_q[2:0]), .drv(addr_q[6:5]),
    .burst_beats(burst_beats_o), .burst_ilv(burst_ilv_o), .cas_lat(cas_lat_o),
    .wr_single(wr_single_o), .mode_valid(mode_valid_o), .mode_bad(mode_bad_o),
    .sr_banks(sr_banks_o), .drv_str(drv_str_o), .ext_valid(ext_valid_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o      <= '0;
      cmd_bank_o <= '0;
      cmd_addr_o <= '0;
      cmd_a10_o  <= 1'b0;
      illegal_o  <= 1'b0;
      wake_o     <= 1'b0;
      guard      <= '0;
    end else begin
      cmd_o      <= cmd_c;
      cmd_bank_o <= ba_q;
      cmd_addr_o <= addr_q;
      cmd_a10_o  <= addr_q[10];
      illegal_o  <= illegal_c;
      wake_o     <= wake_c;
      if (cmd_c[CI_MRS] || cmd_c[CI_EMRS]) guard <= GW'(MRD_CYC);
      else if (guard != '0)                 guard <= guard - 1'b1;
    end
  end
endmodule

// File: rtl/sdram_cmd_decode_chk.sv
module sdram_cmd_decode_chk
  import sdram_dec_pkg::*;
#(
  parameter int CNTW = 11
) (
  input logic            clk,
  input logic            rst,
  input logic [NCMD-1:0] cmd_o,
  input logic            wake_o,
  input logic            mode_valid_o,
  input logic            mode_bad_o,
  input logic [1:0]      cas_lat_o,
  input logic [CNTW-1:0] burst_beats_o
);
  // R1
  cmd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_o));

  // R8
  load_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o[CI_MRS] || cmd_o[CI_EMRS]) |=>
      !(cmd_o[CI_ACT] || cmd_o[CI_AREF] || cmd_o[CI_SREF]));

  // R10
  wake_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> ((cmd_o & ~((NCMD'(1) << CI_NOP) | (NCMD'(1) << CI_DESEL))) == '0));

  // R6
  cas_legal_chk: assert property (@(posedge clk) disable iff (rst)
    mode_valid_o |-> cas_lat_o[1]);

  // R11
  bad_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_bad_o) |-> (cmd_o[CI_MRS] || cmd_o[CI_EMRS]));

  // R11
  fields_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_o[CI_MRS] |-> $stable(burst_beats_o));
endmodule

bind sdram_cmd_decode sdram_cmd_decode_chk #(.CNTW(CNTW)) u_chk (
  .clk(clk), .rst(rst), .cmd_o(cmd_o), .wake_o(wake_o),
  .mode_valid_o(mode_valid_o), .mode_bad_o(mode_bad_o),
  .cas_lat_o(cas_lat_o), .burst_beats_o(burst_beats_o)
);

// File: tb/sdram_cmd_decode_test.sv
module sdram_cmd_decode_test;
  import sdram_dec_pkg::*;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic [11:0] cmd_o;
  logic [1:0]  cmd_bank_o;
  logic [12:0] cmd_addr_o;
  logic        cmd_a10_o, illegal_o, wake_o;
  logic [10:0] burst_beats_o;
  logic        burst_ilv_o;
  logic [1:0]  cas_lat_o;
  logic        wr_single_o, mode_valid_o, mode_bad_o;
  logic [3:0]  sr_banks_o;
  logic [1:0]  drv_str_o;
  logic        ext_valid_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic        m_valid = 0, m_bad = 0, m_ilv = 0, m_wr = 0;
  logic [10:0] m_beats = '0;
  logic [1:0]  m_cas = '0;
  logic        e_valid = 0;
  logic [3:0]  e_mask = '0;
  logic [1:0]  e_drv = '0;

  always #(CLK_P/2) clk = ~clk;

  sdram_cmd_decode uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cke(cke), .ba(ba), .addr(addr), .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o),
    .cmd_addr_o(cmd_addr_o), .cmd_a10_o(cmd_a10_o), .illegal_o(illegal_o),
    .wake_o(wake_o), .burst_beats_o(burst_beats_o), .burst_ilv_o(burst_ilv_o),
    .cas_lat_o(cas_lat_o), .wr_single_o(wr_single_o), .mode_valid_o(mode_valid_o),
    .mode_bad_o(mode_bad_o), .sr_banks_o(sr_banks_o), .drv_str_o(drv_str_o),
    .ext_valid_o(ext_valid_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // c = {cs_n, ras_n, cas_n, we_n}
  task automatic cmd2(input logic [3:0] c, input logic ck, input logic ck_after,
                      input logic [1:0] b, input logic [12:0] a);
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = c; cke = ck; ba = b; addr = a;
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = 4'b0111; cke = ck_after; ba = '0; addr = '0;
    @(posedge clk);
    #(CLK_P/4);
  endtask

  function automatic logic [11:0] bitv(input int i);
    return (i < 0) ? 12'h000 : (12'h001 << i);
  endfunction

  function automatic int exp_idx(input logic [3:0] c, input logic [1:0] b, input logic ck);
    if (c[3]) return CI_DESEL;
    case (c[2:0])
      3'b111: return CI_NOP;
      3'b011: return CI_ACT;
      3'b101: return CI_READ;
      3'b100: return CI_WRITE;
      3'b010: return CI_PRE;
      3'b001: return ck ? CI_AREF : CI_SREF;
      3'b110: return ck ? CI_BST : CI_DPD;
      default: return (b == 2'b00) ? CI_MRS : ((b == 2'b10) ? CI_EMRS : -1);
    endcase
  endfunction

  task automatic load_main(input logic [12:0] a);
    logic [2:0] bl, cl;
    logic ok;
    bl = a[2:0]; cl = a[6:4];
    ok = (cl == 3'd2 || cl == 3'd3) && (bl <= 3'd3 || (bl == 3'd7 && !a[3]));
    cmd2(4'b0000, 1, 1, 2'b00, a);
    if (ok) begin
      m_valid = 1; m_bad = 0; m_ilv = a[3]; m_wr = a[9]; m_cas = cl[1:0];
      m_beats = (bl == 3'd7) ? 11'd1024 : (11'd1 << bl);
    end else m_bad = 1;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    // R12 reset state
    check("R12 cmd", cmd_o, 0);
    check("R12 flags", {illegal_o, wake_o, mode_valid_o, mode_bad_o, ext_valid_o}, 0);
    check("R12 fields", {burst_beats_o, burst_ilv_o, cas_lat_o, wr_single_o, sr_banks_o, drv_str_o}, 0);
    @(negedge clk); rst = 1'b0;

    // R1 sweep of every control pattern, load pattern last
    for (int c = 15; c >= 0; c--) begin
      cmd2(4'(c), 1, 1, 2'b00, 13'h032);
      check("R1 decode", {illegal_o, cmd_o}, {1'b0, bitv(exp_idx(4'(c), 2'b00, 1'b1))});
      if (c == 0) begin
        m_valid = 1; m_beats = 11'd4; m_cas = 2'd3; m_ilv = 0; m_wr = 0; m_bad = 0;
      end
    end

    // R6 R11 exhaustive main register sweep
    for (int cl = 0; cl < 8; cl++)
      for (int bt = 0; bt < 2; bt++)
        for (int bl = 0; bl < 8; bl++) begin
          logic [12:0] a;
          a = 13'((((bl ^ cl) & 1) << 9) | (cl << 4) | (bt << 3) | bl);
          load_main(a);
          check("R6 R11 main fields",
                {mode_valid_o, mode_bad_o, burst_beats_o, burst_ilv_o, cas_lat_o, wr_single_o},
                {m_valid, m_bad, m_beats, m_ilv, m_cas, m_wr});
        end

    // R7 R11 exhaustive extended register sweep
    for (int p = 0; p < 8; p++)
      for (int d = 0; d < 4; d++) begin
        cmd2(4'b0000, 1, 1, 2'b10, 13'((d << 5) | p));
        if (p <= 2) begin
          e_valid = 1; e_drv = 2'(d); m_bad = 0;
          e_mask = (p == 0) ? 4'hF : ((p == 1) ? 4'h3 : 4'h1);
        end else m_bad = 1;
        check("R7 R11 ext fields", {cmd_o[CI_EMRS], ext_valid_o, mode_bad_o, sr_banks_o, drv_str_o},
              {1'b1, e_valid, m_bad, e_mask, e_drv});
      end

    // R2 bank, address and bit 10
    cmd2(4'b0101, 1, 1, 2'b11, 13'h0405);
    check("R2 read ap", {cmd_o, cmd_bank_o, cmd_a10_o, cmd_addr_o},
          {bitv(CI_READ), 2'b11, 1'b1, 13'h0405});
    cmd2(4'b0010, 1, 1, 2'b10, 13'h0000);
    check("R2 pre one bank", {cmd_o, cmd_bank_o, cmd_a10_o}, {bitv(CI_PRE), 2'b10, 1'b0});

    // R5 bad bank select on load
    load_main(13'h032);
    cmd2(4'b0111, 1, 1, 2'b00, 13'h0); // let guard window lapse
    cmd2(4'b0000, 1, 1, 2'b01, 13'h021);
    check("R5 ba01", {illegal_o, cmd_o, burst_beats_o, cas_lat_o}, {1'b1, 12'h000, m_beats, m_cas});
    cmd2(4'b0000, 1, 1, 2'b11, 13'h3);
    check("R5 ba11", {illegal_o, cmd_o, sr_banks_o}, {1'b1, 12'h000, e_mask});

    // R8 guard window after a load
    load_main(13'h032);
    cmd2(4'b0011, 1, 1, 2'b00, 13'h0);
    check("R8 act blocked", {illegal_o, cmd_o}, {1'b1, 12'h000});
    cmd2(4'b0011, 1, 1, 2'b00, 13'h0);
    check("R8 act accepted", {illegal_o, cmd_o}, {1'b0, bitv(CI_ACT)});
    load_main(13'h032);
    cmd2(4'b0001, 1, 1, 2'b00, 13'h0);
    check("R8 refresh blocked", {illegal_o, cmd_o}, {1'b1, 12'h000});
    cmd2(4'b0001, 1, 1, 2'b00, 13'h0);
    check("R3 auto refresh", {illegal_o, cmd_o}, {1'b0, bitv(CI_AREF)});

    // R3 self-refresh entry, then R10 wake with no-op
    cmd2(4'b0001, 0, 0, 2'b00, 13'h0);
    check("R3 self refresh", {illegal_o, cmd_o}, {1'b0, bitv(CI_SREF)});
    cmd2(4'b0111, 1, 1, 2'b00, 13'h0);
    check("R10 wake nop", {wake_o, illegal_o, cmd_o}, {1'b1, 1'b0, bitv(CI_NOP)});

    // R4 deep power-down, R9 held low, R10 bad wake
    cmd2(4'b0110, 0, 0, 2'b00, 13'h0);
    check("R4 deep pd", {illegal_o, cmd_o}, {1'b0, bitv(CI_DPD)});
    cmd2(4'b0101, 0, 0, 2'b00, 13'h0);
    check("R9 cke low", {wake_o, illegal_o, cmd_o}, {1'b0, 1'b0, 12'h000});
    cmd2(4'b0101, 1, 1, 2'b00, 13'h0);
    check("R10 wake read", {wake_o, illegal_o, cmd_o}, {1'b1, 1'b1, 12'h000});
    cmd2(4'b0111, 0, 0, 2'b00, 13'h0);
    check("R1 nop cke fall", cmd_o, bitv(CI_NOP));
    cmd2(4'b1111, 1, 1, 2'b00, 13'h0);
    check("R10 wake deselect", {wake_o, illegal_o, cmd_o}, {1'b1, 1'b0, bitv(CI_DESEL)});
    cmd2(4'b0110, 1, 1, 2'b00, 13'h0);
    check("R4 burst stop", {illegal_o, cmd_o}, {1'b0, bitv(CI_BST)});

    done = 1;
    summary();
    $finish;
  end
endmodule